// File: doc/BRIEF.md
# Debug Exception Entry Controller

This block carries out the one-step entry into debug mode for a simple 32-bit processor. When the pipeline raises a debug-exception request with a one-hot cause code, the block saves the address at which execution must later resume into a debug-PC register. It also records in a debug status register why the exception was taken, whether the faulting instruction sat in a branch delay slot, and whether the core was halted or dozing. It then sets the debug-mode bit and issues a fetch redirect to the debug vector. Two vector addresses exist, and a probe-trap configuration bit chooses between them.

A debug-return input leaves debug mode. It clears the debug-mode bit and redirects fetch to the saved debug PC. The redirect output is a single-cycle pulse with no back-pressure, because the fetch unit must take it. The request and return inputs are likewise plain level-sampled controls. Apart from the debug PC and the debug status fields, no state changes on entry.

Top module: `dbgx_entry_ctrl`

## Requirements
- R1: When a request is accepted and the in-delay-slot input is 0, the debug PC becomes the current PC and the delay-slot flag becomes 0.
- R2: When a request is accepted and the in-delay-slot input is 1, the debug PC becomes the current PC minus 4 (modulo 2^32) and the delay-slot flag becomes 1.
- R3: On acceptance the cause field holds exactly one set bit: bit 0 single-step, bit 1 breakpoint instruction, bit 2 data load break, bit 3 data store break, bit 4 instruction break, bit 5 debug interrupt. If several request bits are set, the lowest-numbered one is kept. A request with no cause bit set is not accepted.
- R4: On acceptance the halt and doze bits take the values of the halt and doze status inputs in the request cycle.
- R5: Acceptance sets the debug-mode bit.
- R6: Acceptance produces a redirect to 0xFF200200 when the probe-trap input is 1 and to 0xBFC00480 when it is 0, whatever the cause.
- R7: All of the entry updates and the redirect appear together, on the first rising edge at which the request is sampled.
- R8: A request made while debug mode is set is ignored. The debug PC, cause, delay-slot, halt and doze fields stay unchanged, and no redirect is issued.
- R9: A debug return sampled while debug mode is set clears debug mode on that edge and redirects to the saved debug PC. A return takes priority over a request in the same cycle. A return made outside debug mode has no effect.
- R10: The redirect valid output is high for one cycle per accepted entry or return.
- R11: A synchronous active-high reset clears debug mode, the cause, delay-slot, halt and doze fields, the debug PC and the redirect outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Debug exception request |
| exc_cause | input | 6 | Cause code, one bit per exception type |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction is in a branch delay slot |
| halt_status | input | 1 | Core halt status at the request |
| doze_status | input | 1 | Core doze status at the request |
| probe_trap | input | 1 | Selects the probe-side debug vector |
| dbg_return | input | 1 | Return from debug mode |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Fetch redirect address |
| debug_pc | output | 32 | Saved restart address |
| dbg_mode | output | 1 | Debug-mode bit |
| dbg_cause | output | 6 | Recorded cause bits |
| dbg_delay_slot | output | 1 | Restart address points at a branch |
| dbg_halt | output | 1 | Captured halt status |
| dbg_doze | output | 1 | Captured doze status |

## Verification
Several properties are checked on every cycle. Each rise of debug mode must carry the correct restart address and delay-slot flag, and the vector must match the probe-trap bit sampled in the previous cycle. Debug mode must always hold exactly one cause bit, requests inside debug mode must leave the saved state alone, and a return must redirect to the saved address. Other behaviour can only be shown by the bench scenarios. These cover the lowest-bit choice among several cause bits, the rejection of an empty cause code, the return-over-request priority, the single-cycle length of the redirect pulse, and the halt and doze capture across all four combinations.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;
  localparam int ADDR_W  = 32;
  localparam int CAUSE_W = 6;
  localparam int INSN_BYTES = 4;

  typedef enum logic [2:0] {
    CZ_SSTEP = 3'd0,
    CZ_BRKPT = 3'd1,
    CZ_DLOAD = 3'd2,
    CZ_DSTOR = 3'd3,
    CZ_IBRK  = 3'd4,
    CZ_DINT  = 3'd5
  } cause_idx_e;

  typedef struct packed {
    logic               dm;
    logic               bd;
    logic               halt;
    logic               doze;
    logic [CAUSE_W-1:0] cause;
  } dbg_status_t;
endpackage

// File: rtl/dbgx_cause_pick.sv
module dbgx_cause_pick #(
  parameter int W = dbgx_pkg::CAUSE_W
) (
  input  logic [W-1:0] req_bits,
  output logic [W-1:0] pick_1h,
  output logic         any
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_pick
    assign pick_1h[i] = req_bits[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | req_bits[i];
  end

  assign any = seen[W];
endmodule

// File: rtl/dbgx_restart_calc.sv
module dbgx_restart_calc #(
  parameter int ADDR_W = dbgx_pkg::ADDR_W,
  parameter int STEP   = dbgx_pkg::INSN_BYTES
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              in_slot,
  output logic [ADDR_W-1:0] restart
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  assign restart = in_slot ? (pc - STEP_V) : pc;
endmodule

// File: rtl/dbgx_regs.sv
module dbgx_regs
  import dbgx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          ret,
  input  logic [AW-1:0] restart_pc,
  input  logic          slot,
  input  logic [CW-1:0] cause_1h,
  input  logic          halt_in,
  input  logic          doze_in,
  input  logic [AW-1:0] vector,
  output logic [AW-1:0] depc_q,
  output dbg_status_t   stat_q,
  output logic          rdir_v_q,
  output logic [AW-1:0] rdir_pc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      depc_q    <= '0;
      stat_q    <= '0;
      rdir_v_q  <= 1'b0;
      rdir_pc_q <= '0;
    end else if (ret) begin
      stat_q.dm <= 1'b0;
      rdir_v_q  <= 1'b1;
      rdir_pc_q <= depc_q;
    end else if (take) begin
      depc_q      <= restart_pc;
      stat_q.dm   <= 1'b1;
      stat_q.bd   <= slot;
      stat_q.halt <= halt_in;
      stat_q.doze <= doze_in;
      stat_q.cause <= cause_1h;
      rdir_v_q    <= 1'b1;
      rdir_pc_q   <= vector;
    end else begin
      rdir_v_q <= 1'b0;
    end
  end

  // R11: reset state
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!stat_q.dm && depc_q == '0 && stat_q.cause == '0 && !stat_q.bd && !rdir_v_q));

  // R3: debug mode always carries one cause
  p_one_cause_r3: assert property (@(posedge clk) disable iff (rst)
    stat_q.dm |-> ($countones(stat_q.cause) == 1));

  // R9: return clears mode and redirects to saved PC
  p_return_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_q.dm && ret) |=> (!stat_q.dm && rdir_v_q && rdir_pc_q == $past(depc_q)));
endmodule

// File: rtl/dbgx_entry_ctrl.sv
module dbgx_entry_ctrl
  import dbgx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CAUSE_W,
  parameter logic [AW-1:0] VEC_PROBE  = AW'(32'hFF20_0200),
  parameter logic [AW-1:0] VEC_NORMAL = AW'(32'hBFC0_0480)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exc_req,
  input  logic [CW-1:0] exc_cause,
  input  logic [AW-1:0] cur_pc,
  input  logic          in_delay_slot,
  input  logic          halt_status,
  input  logic          doze_status,
  input  logic          probe_trap,
  input  logic          dbg_return,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic [AW-1:0] debug_pc,
  output logic          dbg_mode,
  output logic [CW-1:0] dbg_cause,
  output logic          dbg_delay_slot,
  output logic          dbg_halt,
  output logic          dbg_doze
);
  logic [CW-1:0] cause_1h;
  logic          cause_any;
  logic [AW-1:0] restart;
  logic [AW-1:0] vector;
  logic          take, ret;
  dbg_status_t   stat;

  dbgx_cause_pick #(.W(CW)) u_pick (
    .req_bits (exc_cause),
    .pick_1h  (cause_1h),
    .any      (cause_any)
  );

  dbgx_restart_calc #(.ADDR_W(AW), .STEP(INSN_BYTES)) u_restart (
    .pc      (cur_pc),
    .in_slot (in_delay_slot),
    .restart (restart)
  );

  assign vector = probe_trap ? VEC_PROBE : VEC_NORMAL;
  assign ret    = dbg_return & stat.dm;
  assign take   = exc_req & cause_any & ~stat.dm;

  dbgx_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .take       (take),
    .ret        (ret),
    .restart_pc (restart),
    .slot       (in_delay_slot),
    .cause_1h   (cause_1h),
    .halt_in    (halt_status),
    .doze_in    (doze_status),
    .vector     (vector),
    .depc_q     (debug_pc),
    .stat_q     (stat),
    .rdir_v_q   (redirect_valid),
    .rdir_pc_q  (redirect_pc)
  );

  assign dbg_mode       = stat.dm;
  assign dbg_cause      = stat.cause;
  assign dbg_delay_slot = stat.bd;
  assign dbg_halt       = stat.halt;
  assign dbg_doze       = stat.doze;

  // R5: accepted request enters debug mode
  p_enter_dm_r5: assert property (@(posedge clk) disable iff (rst)
    (exc_req && (exc_cause != '0) && !dbg_mode && !dbg_return) |=> dbg_mode);

  // R1/R2: restart address and delay-slot flag on entry
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    (exc_req && (exc_cause != '0) && !dbg_mode) |=>
      (debug_pc == ($past(in_delay_slot) ? $past(cur_pc) - AW'(4) : $past(cur_pc))
       && dbg_delay_slot == $past(in_delay_slot)));

  // R6: vector follows the probe-trap bit
  p_vector_r6: assert property (@(posedge clk) disable iff (rst)
    (exc_req && (exc_cause != '0) && !dbg_mode) |=>
      (redirect_valid && redirect_pc == ($past(probe_trap) ? VEC_PROBE : VEC_NORMAL)));

  // R8: requests inside debug mode leave saved state alone
  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (dbg_mode && exc_req) |=>
      ($stable(debug_pc) && $stable(dbg_cause) && $stable(dbg_delay_slot)
       && $stable(dbg_halt) && $stable(dbg_doze)));
endmodule

// File: tb/dbgx_entry_ctrl_bench.sv
module dbgx_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VP = 32'hFF20_0200;
  localparam logic [31:0] VN = 32'hBFC0_0480;

  logic        clk = 1'b0;
  logic        rst;
  logic        exc_req;
  logic [5:0]  exc_cause;
  logic [31:0] cur_pc;
  logic        in_delay_slot, halt_status, doze_status, probe_trap, dbg_return;
  logic        redirect_valid;
  logic [31:0] redirect_pc, debug_pc;
  logic        dbg_mode;
  logic [5:0]  dbg_cause;
  logic        dbg_delay_slot, dbg_halt, dbg_doze;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgx_entry_ctrl u_dbgx_entry_ctrl (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_cause(exc_cause),
    .cur_pc(cur_pc), .in_delay_slot(in_delay_slot), .halt_status(halt_status),
    .doze_status(doze_status), .probe_trap(probe_trap), .dbg_return(dbg_return),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .debug_pc(debug_pc),
    .dbg_mode(dbg_mode), .dbg_cause(dbg_cause), .dbg_delay_slot(dbg_delay_slot),
    .dbg_halt(dbg_halt), .dbg_doze(dbg_doze)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    exc_req = 1'b0; exc_cause = '0; dbg_return = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; idle(); cur_pc = '0; in_delay_slot = 0;
    halt_status = 0; doze_status = 0; probe_trap = 0;
    @(negedge clk); cyc();
    // R11 reset state
    chk(!dbg_mode && debug_pc == 0 && dbg_cause == 0 && !dbg_delay_slot && !redirect_valid,
        "R11 reset", {dbg_mode, dbg_cause, debug_pc[23:0]}, 0);
    rst = 1'b0;

    for (int pt = 0; pt < 2; pt++)
      for (int sl = 0; sl < 2; sl++)
        for (int ci = 0; ci < 6; ci++)
          for (int hd = 0; hd < 4; hd++) begin
            automatic int it = ((pt*2 + sl)*6 + ci)*4 + hd;
            automatic logic [31:0] pc = it * 32'h0101_0104;
            automatic logic [31:0] xp = sl ? pc - 32'd4 : pc;
            automatic logic [31:0] xv = pt ? VP : VN;
            cur_pc = pc; in_delay_slot = sl[0]; probe_trap = pt[0];
            halt_status = hd[1]; doze_status = hd[0];
            exc_req = 1; exc_cause = 6'(1 << ci);
            cyc();
            idle();
            chk(debug_pc == xp, sl ? "R2 restart pc" : "R1 restart pc", debug_pc, xp);
            chk(dbg_delay_slot == sl[0], "R1 R2 slot flag", 32'(dbg_delay_slot), 32'(sl));
            chk(dbg_cause == 6'(1 << ci), "R3 cause", 32'(dbg_cause), 32'(1 << ci));
            chk({dbg_halt, dbg_doze} == hd[1:0], "R4 halt doze", 32'({dbg_halt, dbg_doze}), 32'(hd));
            chk(dbg_mode, "R5 debug mode", 32'(dbg_mode), 1);
            chk(redirect_valid && redirect_pc == xv, "R6 R7 vector", redirect_pc, xv);
            // R8 request in debug mode ignored
            cur_pc = ~pc; in_delay_slot = ~sl[0]; halt_status = ~hd[1]; doze_status = ~hd[0];
            exc_req = 1; exc_cause = 6'(1 << ((ci + 1) % 6));
            cyc();
            idle();
            chk(!redirect_valid, "R10 pulse length", 32'(redirect_valid), 0);
            chk(debug_pc == xp && dbg_cause == 6'(1 << ci) && dbg_delay_slot == sl[0]
                && {dbg_halt, dbg_doze} == hd[1:0], "R8 ignored", debug_pc, xp);
            // R9 return
            dbg_return = 1;
            cyc();
            idle();
            chk(!dbg_mode && redirect_valid && redirect_pc == xp, "R9 return", redirect_pc, xp);
            cyc();
            chk(!redirect_valid, "R10 return pulse", 32'(redirect_valid), 0);
          end

    // R9 return outside debug mode has no effect
    dbg_return = 1; cyc(); idle();
    chk(!redirect_valid && !dbg_mode, "R9 stray return", 32'(redirect_valid), 0);

    // R3 empty cause not accepted
    exc_req = 1; exc_cause = 6'b0; cur_pc = 32'h1234_5678; cyc(); idle();
    chk(!dbg_mode && !redirect_valid, "R3 empty cause", 32'(dbg_mode), 0);

    // R3 lowest bit kept
    exc_req = 1; exc_cause = 6'b101100; in_delay_slot = 0; probe_trap = 0; cyc(); idle();
    chk(dbg_cause == 6'b000100, "R3 multi cause", 32'(dbg_cause), 32'h4);
    chk(debug_pc == 32'h1234_5678, "R1 after multi", debug_pc, 32'h1234_5678);

    // R9 return wins over request
    dbg_return = 1; exc_req = 1; exc_cause = 6'b000001; cur_pc = 32'hAAAA_0000; cyc(); idle();
    chk(!dbg_mode && redirect_pc == 32'h1234_5678 && debug_pc == 32'h1234_5678,
        "R9 priority", debug_pc, 32'h1234_5678);

    // R11 reset while in debug mode
    exc_req = 1; exc_cause = 6'b010000; cur_pc = 32'h0000_0040; in_delay_slot = 1; cyc(); idle();
    chk(dbg_mode && debug_pc == 32'h3C, "R2 pre-reset entry", debug_pc, 32'h3C);
    rst = 1; cyc(); rst = 0;
    chk(!dbg_mode && debug_pc == 0 && dbg_cause == 0 && !dbg_delay_slot && !dbg_halt && !dbg_doze
        && !redirect_valid && redirect_pc == 0, "R11 reset in debug", debug_pc, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule